// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block is the register-transfer and arithmetic core of a small 8-bit processor. It holds two 8-bit accumulators (A and B, which together read as the 16-bit word D with A in the upper byte), a 16-bit index register X, a 16-bit stack pointer S and the condition flags. Each clock cycle in which `opValid` is high, it applies one operation and updates the registers and flags at that edge. The operation is selected by `opKind`. For byte operations, `selB` picks the target accumulator. The operand comes in on `operand`. Byte operations use its low byte and word operations use all 16 bits.

The unit covers byte add and subtract with and without carry, compare, logic operations, load, test, clear, increment, decrement, negate, complement, byte shifts and rotates, word add, subtract, load and shifts, an 8×8 multiply, index arithmetic, a D/X swap, accumulator-to-accumulator transfer, and the offset transfers between X and S. Fetch, addressing and memory access are handled outside the block. The flag rules are specific to this unit: multiply takes its carry from bit 7 of the low product byte, word shifts set V to N XOR C, adding B to X leaves every flag as it was, and the X/S transfers apply a one-count offset.

Top module: `accAlu`

## Requirements
- R1: After reset A, B, X and S are 0. The flag byte `ccOut` reads 0xD0. Its layout is bit7=1, bit6=1, bit5=H (half carry), bit4=I (interrupt mask, 1 after reset and never changed by this unit), bit3=N, bit2=Z, bit1=V, bit0=C.
- R2: Byte add (opKind 1) and add-with-carry (opKind 2) write target + operand (+C for opKind 2). H is the carry out of bit 3, V is signed overflow, C is the carry out of bit 7, and N and Z follow the result.
- R3: Subtract (3), subtract-with-borrow (4) and compare (5) compute target − operand (−C for 4). C is the borrow, V is signed overflow, H is unchanged, and compare leaves the accumulator unchanged.
- R4: AND (6), OR (7), XOR (8), load (9, target = operand byte) and transfer (29, target = the other accumulator) set N and Z from the result and clear V, leaving C and H unchanged. Test (11) sets N and Z from the target, clears V and C, and writes nothing.
- R5: Clear (10) writes 0 to the target and leaves Z=1 and N=V=C=0.
- R6: Increment (12) sets V only on a result of 0x80. Decrement (13) sets V only on a result of 0x7F. Both leave C unchanged. Negate (14) writes 0 − target, sets V on 0x80 and C on any non-zero result. Complement (15) inverts the target, clears V and sets C.
- R7: Byte shifts: shift left (16), arithmetic right (17), logical right (18), rotate left (19) and rotate right (20). The shifted-out bit goes to C, the rotates shift the old C in, and V = N XOR C afterwards.
- R8: Word add (21), word subtract (22) and word load (23) act on D with the 16-bit operand. For add and subtract, C and V follow bit 15. Load clears V and keeps C. N and Z come from the 16-bit result.
- R9: Word shift left (24) moves old D bit 15 into C. Word logical shift right (25) moves old D bit 0 into C. In both, V = N XOR C afterwards and N and Z come from the 16-bit result.
- R10: Multiply (26) writes A×B into D and sets C from bit 7 of the new B. H, N, Z and V are unchanged.
- R11: Add-B-to-X (27) adds B, zero-extended, to X. Swap (28) exchanges D and X. Neither changes any flag.
- R12: X-to-S (30) loads S with X−1 and S-to-X (31) loads X with S+1, both modulo 2^16 and both without touching flags.
- R13: X increment (32) and decrement (33) change only Z, from the new X. S increment (34) and decrement (35) change no flag.
- R14: With `opValid` low, or with an unassigned opKind (0 or 36 to 63), no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Apply `opKind` at this edge |
| opKind | input | 6 | Operation code (values listed in the requirements) |
| selB | input | 1 | Byte operations target B when 1 and A when 0 |
| operand | input | 16 | Operand: low byte for byte operations, all bits for word operations |
| aOut | output | 8 | Accumulator A |
| bOut | output | 8 | Accumulator B |
| xOut | output | 16 | Index register X |
| sOut | output | 16 | Stack pointer S |
| ccOut | output | 8 | Flag byte, layout given in R1 |

## Verification
No operation writes the flag byte directly, so the hardest cases to reach are the ones that need a particular incoming C, V or H, such as a rotate shifting in a set carry, subtract-with-borrow with C set, or a transfer that must clear a V left set by an earlier overflow. The stimulus builds each precondition with a chain of operations whose flag effects are fixed: complement to set C, clear or test to drop it, and a signed overflow on a byte add to raise V. The next operation then runs on that prepared state. The wrap cases of the X/S offset transfers and of X decrement are reached by swapping a zero word into X first.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 6'd0,  OP_ADD    = 6'd1,  OP_ADC    = 6'd2,  OP_SUB    = 6'd3,
    OP_SBC    = 6'd4,  OP_CMP    = 6'd5,  OP_AND    = 6'd6,  OP_OR     = 6'd7,
    OP_XOR    = 6'd8,  OP_LOAD   = 6'd9,  OP_CLEAR  = 6'd10, OP_TEST   = 6'd11,
    OP_INC    = 6'd12, OP_DEC    = 6'd13, OP_NEG    = 6'd14, OP_COMPL  = 6'd15,
    OP_SHL    = 6'd16, OP_SAR    = 6'd17, OP_SHR    = 6'd18, OP_ROTL   = 6'd19,
    OP_ROTR   = 6'd20, OP_WADD   = 6'd21, OP_WSUB   = 6'd22, OP_WLOAD  = 6'd23,
    OP_WSHL   = 6'd24, OP_WSHR   = 6'd25, OP_MUL    = 6'd26, OP_ADDBX  = 6'd27,
    OP_SWAPDX = 6'd28, OP_XFER   = 6'd29, OP_XTOS   = 6'd30, OP_STOX   = 6'd31,
    OP_INCX   = 6'd32, OP_DECX   = 6'd33, OP_INCS   = 6'd34, OP_DECS   = 6'd35
  } opKind_e;

  typedef enum logic [3:0] {
    F8_PASS, F8_ADD, F8_SUB, F8_AND, F8_OR, F8_XOR, F8_CLR, F8_INC,
    F8_DEC, F8_NEG, F8_COM, F8_SHL, F8_SAR, F8_SHR, F8_ROL, F8_ROR
  } fn8_e;

  typedef enum logic [2:0] {F16_PASS, F16_ADD, F16_SUB, F16_SHL, F16_SHR} fn16_e;

  typedef enum logic [1:0] {ASEL_ACC, ASEL_OPND, ASEL_OTHER} aSel_e;

  typedef enum logic [2:0] {FL_NONE, FL_BYTE, FL_WORD, FL_MUL, FL_ZONLY} flSrc_e;

  typedef enum logic [3:0] {
    IX_NONE, IX_ADDB, IX_SWAP, IX_XTOS, IX_STOX, IX_INCX, IX_DECX, IX_INCS, IX_DECS
  } idxOp_e;

  typedef struct packed {
    fn8_e   fn8;
    aSel_e  aSel;
    logic   useCarry;
    logic   clrC;
    logic   wrAcc;
    fn16_e  fn16;
    logic   wrWord;
    logic   doMul;
    idxOp_e idxOp;
    flSrc_e flSrc;
  } strobes_t;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opKind,
  output strobes_t        stb
);
  always_comb begin
    stb = '0;
    if (opValid) begin
      case (opKind_e'(opKind))
        OP_ADD:    begin stb.fn8 = F8_ADD; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_ADC:    begin stb.fn8 = F8_ADD; stb.useCarry = 1'b1; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_SUB:    begin stb.fn8 = F8_SUB; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_SBC:    begin stb.fn8 = F8_SUB; stb.useCarry = 1'b1; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_CMP:    begin stb.fn8 = F8_SUB; stb.flSrc = FL_BYTE; end
        OP_AND:    begin stb.fn8 = F8_AND; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_OR:     begin stb.fn8 = F8_OR;  stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_XOR:    begin stb.fn8 = F8_XOR; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_LOAD:   begin stb.fn8 = F8_PASS; stb.aSel = ASEL_OPND; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_CLEAR:  begin stb.fn8 = F8_CLR; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_TEST:   begin stb.fn8 = F8_PASS; stb.clrC = 1'b1; stb.flSrc = FL_BYTE; end
        OP_INC:    begin stb.fn8 = F8_INC; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_DEC:    begin stb.fn8 = F8_DEC; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_NEG:    begin stb.fn8 = F8_NEG; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_COMPL:  begin stb.fn8 = F8_COM; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_SHL:    begin stb.fn8 = F8_SHL; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_SAR:    begin stb.fn8 = F8_SAR; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_SHR:    begin stb.fn8 = F8_SHR; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_ROTL:   begin stb.fn8 = F8_ROL; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_ROTR:   begin stb.fn8 = F8_ROR; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_XFER:   begin stb.fn8 = F8_PASS; stb.aSel = ASEL_OTHER; stb.wrAcc = 1'b1; stb.flSrc = FL_BYTE; end
        OP_WADD:   begin stb.fn16 = F16_ADD; stb.wrWord = 1'b1; stb.flSrc = FL_WORD; end
        OP_WSUB:   begin stb.fn16 = F16_SUB; stb.wrWord = 1'b1; stb.flSrc = FL_WORD; end
        OP_WLOAD:  begin stb.fn16 = F16_PASS; stb.wrWord = 1'b1; stb.flSrc = FL_WORD; end
        OP_WSHL:   begin stb.fn16 = F16_SHL; stb.wrWord = 1'b1; stb.flSrc = FL_WORD; end
        OP_WSHR:   begin stb.fn16 = F16_SHR; stb.wrWord = 1'b1; stb.flSrc = FL_WORD; end
        OP_MUL:    begin stb.doMul = 1'b1; stb.flSrc = FL_MUL; end
        OP_ADDBX:  stb.idxOp = IX_ADDB;
        OP_SWAPDX: stb.idxOp = IX_SWAP;
        OP_XTOS:   stb.idxOp = IX_XTOS;
        OP_STOX:   stb.idxOp = IX_STOX;
        OP_INCX:   begin stb.idxOp = IX_INCX; stb.flSrc = FL_ZONLY; end
        OP_DECX:   begin stb.idxOp = IX_DECX; stb.flSrc = FL_ZONLY; end
        OP_INCS:   stb.idxOp = IX_INCS;
        OP_DECS:   stb.idxOp = IX_DECS;
        default:   stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/accAlu8.sv
module accAlu8
  import accAluPkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  fn8_e         fn,
  input  logic         carryIn,
  input  logic         useCarry,
  input  logic         clrC,
  input  logic         hIn,
  output logic [W-1:0] res,
  output logic         hOut,
  output logic         nOut,
  output logic         zOut,
  output logic         vOut,
  output logic         cOut
);
  localparam int          NIB      = W / 2;
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext;
  logic       cinEff;

  always_comb begin
    cinEff = useCarry & carryIn;
    ext    = '0;
    res    = opA;
    hOut   = hIn;
    vOut   = 1'b0;
    cOut   = carryIn;
    case (fn)
      F8_ADD: begin
        ext  = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, cinEff};
        res  = ext[W-1:0];
        cOut = ext[W];
        hOut = opA[NIB] ^ opB[NIB] ^ res[NIB];
        vOut = (opA[W-1] == opB[W-1]) && (res[W-1] != opA[W-1]);
      end
      F8_SUB: begin
        ext  = {1'b0, opA} - {1'b0, opB} - {{W{1'b0}}, cinEff};
        res  = ext[W-1:0];
        cOut = ext[W];
        vOut = (opA[W-1] != opB[W-1]) && (res[W-1] != opA[W-1]);
      end
      F8_AND:  res = opA & opB;
      F8_OR:   res = opA | opB;
      F8_XOR:  res = opA ^ opB;
      F8_PASS: cOut = clrC ? 1'b0 : carryIn;
      F8_CLR:  begin res = '0; cOut = 1'b0; end
      F8_INC:  begin res = opA + W'(1); vOut = (res == TOP_ONLY); end
      F8_DEC:  begin res = opA - W'(1); vOut = (res == ~TOP_ONLY); end
      F8_NEG:  begin res = '0 - opA; vOut = (res == TOP_ONLY); cOut = (res != '0); end
      F8_COM:  begin res = ~opA; cOut = 1'b1; end
      F8_SHL:  begin res = {opA[W-2:0], 1'b0};     cOut = opA[W-1]; vOut = res[W-1] ^ cOut; end
      F8_SAR:  begin res = {opA[W-1], opA[W-1:1]}; cOut = opA[0];   vOut = res[W-1] ^ cOut; end
      F8_SHR:  begin res = {1'b0, opA[W-1:1]};     cOut = opA[0];   vOut = res[W-1] ^ cOut; end
      F8_ROL:  begin res = {opA[W-2:0], carryIn};  cOut = opA[W-1]; vOut = res[W-1] ^ cOut; end
      F8_ROR:  begin res = {carryIn, opA[W-1:1]};  cOut = opA[0];   vOut = res[W-1] ^ cOut; end
      default: res = opA;
    endcase
    nOut = res[W-1];
    zOut = (res == '0);
  end
endmodule

// File: rtl/accAluDp.sv
module accAluDp
  import accAluPkg::*;
#(
  parameter logic IRQ_MASK_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              selB,
  input  logic [WORD_W-1:0] operand,
  output logic [BYTE_W-1:0] aOut,
  output logic [BYTE_W-1:0] bOut,
  output logic [WORD_W-1:0] xOut,
  output logic [WORD_W-1:0] sOut,
  output logic [7:0]        ccOut
);
  logic [BYTE_W-1:0] aReg, bReg, tgt, other, aluA, aluRes;
  logic [WORD_W-1:0] xReg, sReg, dReg, wRes, prod, xNext, sNext, dNext;
  logic [WORD_W:0]   w17;
  logic              hF, iF, nF, zF, vF, cF;
  logic              aH, aN, aZ, aV, aC, wN, wZ, wV, wC, dWr;

  assign dReg  = {aReg, bReg};
  assign tgt   = selB ? bReg : aReg;
  assign other = selB ? aReg : bReg;
  assign prod  = WORD_W'(aReg) * WORD_W'(bReg);

  always_comb begin
    case (stb.aSel)
      ASEL_OPND:  aluA = operand[BYTE_W-1:0];
      ASEL_OTHER: aluA = other;
      default:    aluA = tgt;
    endcase
  end

  accAlu8 #(.W(BYTE_W)) uAlu8 (
    .opA(aluA), .opB(operand[BYTE_W-1:0]), .fn(stb.fn8), .carryIn(cF),
    .useCarry(stb.useCarry), .clrC(stb.clrC), .hIn(hF), .res(aluRes),
    .hOut(aH), .nOut(aN), .zOut(aZ), .vOut(aV), .cOut(aC)
  );

  // word unit on D
  always_comb begin
    w17  = '0;
    wRes = operand;
    wV   = 1'b0;
    wC   = cF;
    case (stb.fn16)
      F16_ADD: begin
        w17  = {1'b0, dReg} + {1'b0, operand};
        wRes = w17[WORD_W-1:0];
        wC   = w17[WORD_W];
        wV   = (dReg[WORD_W-1] == operand[WORD_W-1]) && (wRes[WORD_W-1] != dReg[WORD_W-1]);
      end
      F16_SUB: begin
        w17  = {1'b0, dReg} - {1'b0, operand};
        wRes = w17[WORD_W-1:0];
        wC   = w17[WORD_W];
        wV   = (dReg[WORD_W-1] != operand[WORD_W-1]) && (wRes[WORD_W-1] != dReg[WORD_W-1]);
      end
      F16_SHL: begin
        wRes = {dReg[WORD_W-2:0], 1'b0};
        wC   = dReg[WORD_W-1];
        wV   = wRes[WORD_W-1] ^ wC;
      end
      F16_SHR: begin
        wRes = {1'b0, dReg[WORD_W-1:1]};
        wC   = dReg[0];
        wV   = wRes[WORD_W-1] ^ wC;
      end
      default: wRes = operand;
    endcase
    wN = wRes[WORD_W-1];
    wZ = (wRes == '0);
  end

  // index, stack and D write selection
  always_comb begin
    xNext = xReg;
    sNext = sReg;
    dNext = dReg;
    dWr   = 1'b0;
    if (stb.wrWord) begin dNext = wRes; dWr = 1'b1; end
    if (stb.doMul)  begin dNext = prod; dWr = 1'b1; end
    case (stb.idxOp)
      IX_ADDB: xNext = xReg + WORD_W'(bReg);
      IX_SWAP: begin xNext = dReg; dNext = xReg; dWr = 1'b1; end
      IX_XTOS: sNext = xReg - WORD_W'(1);
      IX_STOX: xNext = sReg + WORD_W'(1);
      IX_INCX: xNext = xReg + WORD_W'(1);
      IX_DECX: xNext = xReg - WORD_W'(1);
      IX_INCS: sNext = sReg + WORD_W'(1);
      IX_DECS: sNext = sReg - WORD_W'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0; xReg <= '0; sReg <= '0;
      hF <= 1'b0; iF <= IRQ_MASK_RST; nF <= 1'b0; zF <= 1'b0; vF <= 1'b0; cF <= 1'b0;
    end else begin
      if (dWr) begin
        aReg <= dNext[WORD_W-1:BYTE_W];
        bReg <= dNext[BYTE_W-1:0];
      end else if (stb.wrAcc) begin
        if (selB) bReg <= aluRes;
        else      aReg <= aluRes;
      end
      xReg <= xNext;
      sReg <= sNext;
      case (stb.flSrc)
        FL_BYTE:  begin hF <= aH; nF <= aN; zF <= aZ; vF <= aV; cF <= aC; end
        FL_WORD:  begin nF <= wN; zF <= wZ; vF <= wV; cF <= wC; end
        FL_MUL:   cF <= prod[BYTE_W-1];
        FL_ZONLY: zF <= (xNext == '0);
        default:  ;
      endcase
    end
  end

  assign aOut  = aReg;
  assign bOut  = bReg;
  assign xOut  = xReg;
  assign sOut  = sReg;
  assign ccOut = {2'b11, hF, iF, nF, zF, vF, cF};

  AST_ADDBX_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxOp == IX_ADDB) |=> xReg == $past(xReg) + WORD_W'($past(bReg))); // R11
  AST_ADDBX_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxOp == IX_ADDB) |=> ccOut == $past(ccOut)); // R11
  AST_XTOS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxOp == IX_XTOS) |=> sReg == $past(xReg) - WORD_W'(1)); // R12
  AST_STOX_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxOp == IX_STOX) |=> xReg == $past(sReg) + WORD_W'(1)); // R12
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrAcc && stb.fn8 == F8_CLR) |=> (zF && !nF && !vF && !cF)); // R5
  AST_MUL_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    stb.doMul |=> (cF == bReg[BYTE_W-1]) && (vF == $past(vF)) && (nF == $past(nF))); // R10
  AST_WORD_SHIFT_V: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrWord && (stb.fn16 == F16_SHL || stb.fn16 == F16_SHR)) |=> (vF == (nF ^ cF))); // R9
  AST_STACK_STEP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxOp == IX_INCS || stb.idxOp == IX_DECS) |=> $stable(ccOut)); // R13
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter logic IRQ_MASK_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opKind,
  input  logic              selB,
  input  logic [WORD_W-1:0] operand,
  output logic [BYTE_W-1:0] aOut,
  output logic [BYTE_W-1:0] bOut,
  output logic [WORD_W-1:0] xOut,
  output logic [WORD_W-1:0] sOut,
  output logic [7:0]        ccOut
);
  strobes_t stb;

  accAluCtrl uCtrl (.opValid(opValid), .opKind(opKind), .stb(stb));

  accAluDp #(.IRQ_MASK_RST(IRQ_MASK_RST)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .selB(selB), .operand(operand),
    .aOut(aOut), .bOut(bOut), .xOut(xOut), .sOut(sOut), .ccOut(ccOut)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(aOut) && $stable(bOut) && $stable(xOut) && $stable(sOut) && $stable(ccOut))); // R14
  AST_FLAG_BYTE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ccOut[7:6] == 2'b11 && ccOut[4] == IRQ_MASK_RST); // R1
endmodule

// File: tb/sim_accAlu.sv
`timescale 1ns/1ps
module sim_accAlu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [5:0]  opKind = '0;
  logic        selB = 1'b0;
  logic [15:0] operand = '0;
  logic [7:0]  aOut, bOut, ccOut;
  logic [15:0] xOut, sOut;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [5:0] K_ADD=1, K_ADC=2, K_SUB=3, K_SBC=4, K_CMP=5, K_AND=6, K_OR=7,
    K_XOR=8, K_LOAD=9, K_CLEAR=10, K_TEST=11, K_INC=12, K_DEC=13, K_NEG=14, K_COMPL=15,
    K_SHL=16, K_SAR=17, K_SHR=18, K_ROTL=19, K_ROTR=20, K_WADD=21, K_WSUB=22, K_WLOAD=23,
    K_WSHL=24, K_WSHR=25, K_MUL=26, K_ADDBX=27, K_SWAP=28, K_XFER=29, K_XTOS=30, K_STOX=31,
    K_INCX=32, K_DECX=33, K_INCS=34, K_DECS=35;

  always #2 clk = ~clk;

  accAlu u0 (.clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .selB(selB),
             .operand(operand), .aOut(aOut), .bOut(bOut), .xOut(xOut), .sOut(sOut),
             .ccOut(ccOut));

  function automatic logic [7:0] mkCc(input logic h, n, z, v, c);
    return {2'b11, h, 1'b1, n, z, v, c};
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [5:0] k, input logic b, input logic [15:0] v);
    @(negedge clk);
    opKind = k; selB = b; operand = v; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic chkAcc(input string req, input logic [7:0] a, input logic [7:0] b, input logic [7:0] cc);
    check(req, "A", {8'h00, aOut}, {8'h00, a});
    check(req, "B", {8'h00, bOut}, {8'h00, b});
    check(req, "CC", {8'h00, ccOut}, {8'h00, cc});
  endtask

  task automatic chkIdx(input string req, input logic [15:0] x, input logic [15:0] s, input logic [7:0] cc);
    check(req, "X", xOut, x);
    check(req, "S", sOut, s);
    check(req, "CC", {8'h00, ccOut}, {8'h00, cc});
  endtask

  task automatic tReset;
    chkAcc("R1", 8'h00, 8'h00, 8'hD0);
    chkIdx("R1", 16'h0000, 16'h0000, 8'hD0);
  endtask

  task automatic tAdd;
    doOp(K_LOAD, 0, 16'h003A);
    doOp(K_ADD, 0, 16'h0048);  chkAcc("R2", 8'h82, 8'h00, mkCc(1,1,0,1,0));
    doOp(K_ADD, 0, 16'h0080);  chkAcc("R2", 8'h02, 8'h00, mkCc(0,0,0,1,1));
    doOp(K_ADC, 0, 16'h000F);  chkAcc("R2", 8'h12, 8'h00, mkCc(1,0,0,0,0));
    doOp(K_LOAD, 1, 16'h00FF);
    doOp(K_ADD, 1, 16'h0001);  chkAcc("R2", 8'h12, 8'h00, mkCc(1,0,1,0,1));
  endtask

  task automatic tSub;
    doOp(K_LOAD, 0, 16'h0010); chkAcc("R4", 8'h10, 8'h00, mkCc(1,0,0,0,1));
    doOp(K_SUB, 0, 16'h0020);  chkAcc("R3", 8'hF0, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_SBC, 0, 16'h000F);  chkAcc("R3", 8'hE0, 8'h00, mkCc(1,1,0,0,0));
    doOp(K_CMP, 0, 16'h00E0);  chkAcc("R3", 8'hE0, 8'h00, mkCc(1,0,1,0,0));
    doOp(K_SUB, 0, 16'h0070);  chkAcc("R3", 8'h70, 8'h00, mkCc(1,0,0,1,0));
  endtask

  task automatic tLogic;
    doOp(K_LOAD, 0, 16'h00F0); chkAcc("R4", 8'hF0, 8'h00, mkCc(1,1,0,0,0));
    doOp(K_AND, 0, 16'h000F);  chkAcc("R4", 8'h00, 8'h00, mkCc(1,0,1,0,0));
    doOp(K_COMPL, 0, 16'h0);   chkAcc("R6", 8'hFF, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_OR, 0, 16'h0000);   chkAcc("R4", 8'hFF, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_XOR, 0, 16'h00FF);  chkAcc("R4", 8'h00, 8'h00, mkCc(1,0,1,0,1));
    doOp(K_TEST, 0, 16'h0);    chkAcc("R4", 8'h00, 8'h00, mkCc(1,0,1,0,0));
    doOp(K_LOAD, 1, 16'h007F);
    doOp(K_ADD, 1, 16'h0001);  chkAcc("R2", 8'h00, 8'h80, mkCc(1,1,0,1,0));
    doOp(K_XFER, 0, 16'h0);    chkAcc("R4", 8'h80, 8'h80, mkCc(1,1,0,0,0));
  endtask

  task automatic tClear;
    doOp(K_COMPL, 1, 16'h0);   chkAcc("R6", 8'h80, 8'h7F, mkCc(1,0,0,0,1));
    doOp(K_CLEAR, 1, 16'h0);   chkAcc("R5", 8'h80, 8'h00, mkCc(1,0,1,0,0));
  endtask

  task automatic tUnary;
    doOp(K_LOAD, 0, 16'h007F);
    doOp(K_INC, 0, 16'h0);     chkAcc("R6", 8'h80, 8'h00, mkCc(1,1,0,1,0));
    doOp(K_DEC, 0, 16'h0);     chkAcc("R6", 8'h7F, 8'h00, mkCc(1,0,0,1,0));
    doOp(K_NEG, 0, 16'h0);     chkAcc("R6", 8'h81, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_LOAD, 0, 16'h0080);
    doOp(K_NEG, 0, 16'h0);     chkAcc("R6", 8'h80, 8'h00, mkCc(1,1,0,1,1));
    doOp(K_LOAD, 0, 16'h0000);
    doOp(K_NEG, 0, 16'h0);     chkAcc("R6", 8'h00, 8'h00, mkCc(1,0,1,0,0));
  endtask

  task automatic tShift8;
    doOp(K_LOAD, 0, 16'h0081);
    doOp(K_SHL, 0, 16'h0);     chkAcc("R7", 8'h02, 8'h00, mkCc(1,0,0,1,1));
    doOp(K_ROTR, 0, 16'h0);    chkAcc("R7", 8'h81, 8'h00, mkCc(1,1,0,1,0));
    doOp(K_SAR, 0, 16'h0);     chkAcc("R7", 8'hC0, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_ROTL, 0, 16'h0);    chkAcc("R7", 8'h81, 8'h00, mkCc(1,1,0,0,1));
    doOp(K_SHR, 0, 16'h0);     chkAcc("R7", 8'h40, 8'h00, mkCc(1,0,0,1,1));
  endtask

  task automatic tWord;
    doOp(K_WLOAD, 0, 16'h7FFF); chkAcc("R8", 8'h7F, 8'hFF, mkCc(1,0,0,0,1));
    doOp(K_WADD, 0, 16'h0001);  chkAcc("R8", 8'h80, 8'h00, mkCc(1,1,0,1,0));
    doOp(K_WSUB, 0, 16'h8001);  chkAcc("R8", 8'hFF, 8'hFF, mkCc(1,1,0,0,1));
    doOp(K_WADD, 0, 16'h0001);  chkAcc("R8", 8'h00, 8'h00, mkCc(1,0,1,0,1));
  endtask

  task automatic tWordShift;
    doOp(K_WLOAD, 0, 16'h8001);
    doOp(K_WSHL, 0, 16'h0);    chkAcc("R9", 8'h00, 8'h02, mkCc(1,0,0,1,1));
    doOp(K_WSHR, 0, 16'h0);    chkAcc("R9", 8'h00, 8'h01, mkCc(1,0,0,0,0));
    doOp(K_WSHR, 0, 16'h0);    chkAcc("R9", 8'h00, 8'h00, mkCc(1,0,1,1,1));
  endtask

  task automatic tMul;
    doOp(K_WLOAD, 0, 16'hFFFF);
    doOp(K_MUL, 0, 16'h0);     chkAcc("R10", 8'hFE, 8'h01, mkCc(1,1,0,0,0));
    doOp(K_WLOAD, 0, 16'h0C0B);
    doOp(K_MUL, 0, 16'h0);     chkAcc("R10", 8'h00, 8'h84, mkCc(1,0,0,0,1));
  endtask

  task automatic tIndex;
    doOp(K_WLOAD, 0, 16'h1234);
    doOp(K_SWAP, 0, 16'h0);    chkAcc("R11", 8'h00, 8'h00, mkCc(1,0,0,0,1));
    check("R11", "X after swap", xOut, 16'h1234);
    doOp(K_LOAD, 1, 16'h00F0);
    doOp(K_ADDBX, 0, 16'h0);   chkIdx("R11", 16'h1324, 16'h0000, mkCc(1,1,0,0,1));
  endtask

  task automatic tStackXfer;
    doOp(K_XTOS, 0, 16'h0);    chkIdx("R12", 16'h1324, 16'h1323, mkCc(1,1,0,0,1));
    doOp(K_STOX, 0, 16'h0);    chkIdx("R12", 16'h1324, 16'h1323, mkCc(1,1,0,0,1));
    doOp(K_WLOAD, 0, 16'h0000);
    doOp(K_SWAP, 0, 16'h0);    chkAcc("R11", 8'h13, 8'h24, mkCc(1,0,1,0,1));
    doOp(K_XTOS, 0, 16'h0);    chkIdx("R12", 16'h0000, 16'hFFFF, mkCc(1,0,1,0,1));
    doOp(K_STOX, 0, 16'h0);    chkIdx("R12", 16'h0000, 16'hFFFF, mkCc(1,0,1,0,1));
  endtask

  task automatic tSteps;
    doOp(K_INCX, 0, 16'h0);    chkIdx("R13", 16'h0001, 16'hFFFF, mkCc(1,0,0,0,1));
    doOp(K_DECX, 0, 16'h0);    chkIdx("R13", 16'h0000, 16'hFFFF, mkCc(1,0,1,0,1));
    doOp(K_DECX, 0, 16'h0);    chkIdx("R13", 16'hFFFF, 16'hFFFF, mkCc(1,0,0,0,1));
    doOp(K_INCS, 0, 16'h0);    chkIdx("R13", 16'hFFFF, 16'h0000, mkCc(1,0,0,0,1));
    doOp(K_DECS, 0, 16'h0);    chkIdx("R13", 16'hFFFF, 16'hFFFF, mkCc(1,0,0,0,1));
  endtask

  task automatic tIdle;
    @(negedge clk);
    opKind = K_CLEAR; selB = 1'b0; operand = 16'h0000; opValid = 1'b0;
    repeat (3) @(negedge clk);
    chkAcc("R14", 8'h13, 8'h24, mkCc(1,0,0,0,1));
    doOp(6'd50, 0, 16'hFFFF);  chkAcc("R14", 8'h13, 8'h24, mkCc(1,0,0,0,1));
    doOp(6'd0, 1, 16'hFFFF);   chkIdx("R14", 16'hFFFF, 16'hFFFF, mkCc(1,0,0,0,1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAdd();
    tSub();
    tLogic();
    tClear();
    tUnary();
    tShift8();
    tWord();
    tWordShift();
    tMul();
    tIndex();
    tStackXfer();
    tSteps();
    tIdle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule